// File: doc/BRIEF.md
# Clock Source Mode Controller

This block turns the clock control settings into one operating mode. The settings are a two-bit source select, a reference select, a low-power bit and a debug-active input. From the mode it drives the select of the main output clock mux, the FLL enable, the internal and external reference enables, and the clock enable of the debug link. The FLL output and the two reference clocks come in as free-running inputs. The block also contains the mux that produces `clk_out` from them. That mux changes source without glitches: the old source's gate closes on a falling edge of that source. The new gate opens only after a synchronizer in the new domain has seen the old gate closed.

Requests are taken in the control clock domain. When a legal setting names a mode other than the current one, the block starts a switch, raises `busy` and drives the new mux select. The mode and the enables stay at their old values until the gate pattern, synchronized back into the control domain, shows that only the new source is gated through. At that point the mode and the enables change together and `busy` falls. An illegal setting leaves everything as it is. While debug is active, the low-power bit is overridden, so the FLL and the debug clock keep running.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0, `clk_sel` is 0, {`fll_en`,`int_ref_en`,`ext_ref_en`,`dbg_clk_en`} is 1101, `busy` is 0, and `clk_out` follows `fll_clk`.
- R2: The mode codes are: 0 FLL locked to the internal reference; 1 FLL locked to the external reference; 2 bypass to the internal reference; 3 bypass to the internal reference in low power; 4 bypass to the external reference. `src_sel`=00 selects mode 0 when `ref_int`=1 and mode 1 when `ref_int`=0. `src_sel`=01 with `ref_int`=1 selects mode 2 or 3. `src_sel`=10 with `ref_int`=0 selects mode 4.
- R3: `src_sel`=01 with `ref_int`=1 selects mode 3 only when `low_pwr`=1 and `dbg_active`=0, and mode 2 otherwise. `src_sel`=10 with `ref_int`=0 is legal only when `dbg_active`=1 or `low_pwr`=0.
- R4: After a switch completes, {`fll_en`,`int_ref_en`,`ext_ref_en`,`dbg_clk_en`} is 1101 for mode 0, 1011 for mode 1, 1101 for mode 2, 0100 for mode 3 and 1011 for mode 4.
- R5: `cfg_valid` is combinational. It is 1 for a legal setting, except that with `ref_int`=0 it also needs `div_in_range`=1. It is 0 for every setting not listed in R2 or R3.
- R6: A setting with `cfg_valid`=0 never raises `busy` and leaves `mode` and the enables unchanged.
- R7: `clk_sel` is 0 (FLL) for modes 0 and 1, 1 (internal reference) for modes 2 and 3, and 2 (external reference) for mode 4. It takes the new value one control clock after a request is accepted. Once `busy` has fallen, `clk_out` runs at the period of the selected source.
- R8: `busy` rises one control clock after a legal setting that differs from the current mode. While `busy` is 1, `mode` and `clk_sel` hold. `mode` changes only on the edge at which `busy` falls.
- R9: At most one source gate is open at any time, and no high or low phase of `clk_out` is shorter than half the period of the fastest input clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| fll_clk | input | 1 | FLL output clock |
| int_ref_clk | input | 1 | Internal reference clock |
| ext_ref_clk | input | 1 | External reference clock (divided) |
| src_sel | input | 2 | Clock source select field |
| ref_int | input | 1 | Reference select: 1 internal, 0 external |
| low_pwr | input | 1 | Low-power request bit |
| dbg_active | input | 1 | Debug mode is active |
| div_in_range | input | 1 | Divided external reference is inside its legal band |
| mode | output | 3 | Committed operating mode code |
| cfg_valid | output | 1 | Current settings are a legal configuration |
| clk_sel | output | 2 | Main clock mux select (0 FLL, 1 internal, 2 external) |
| fll_en | output | 1 | FLL enable |
| int_ref_en | output | 1 | Internal reference enable |
| ext_ref_en | output | 1 | External reference enable |
| dbg_clk_en | output | 1 | Debug link clock enable |
| busy | output | 1 | A clock switch is in progress |
| clk_out | output | 1 | Glitch-free main output clock |

## Verification
The hardest condition to reach from the ports is a gate handover between two unrelated clocks. The old source's gate must close on that source's own falling edge while the new synchronizer is still waiting. The bench runs the three input clocks at mutually prime half periods, so each handover lands at a different phase. It steps through every source pair in both directions and measures every high and low phase of `clk_out` against the fastest half period. It also toggles debug while the low-power bit is held at 1, in both the internal and the external bypass settings, to show the override and its loss.

// File: rtl/clk_mode_ctrl.sv
`timescale 1ns/1ps
module clk_mode_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       ctl_clk,
  input  logic       rst_n,
  input  logic       fll_clk,
  input  logic       int_ref_clk,
  input  logic       ext_ref_clk,
  input  logic [1:0] src_sel,
  input  logic       ref_int,
  input  logic       low_pwr,
  input  logic       dbg_active,
  input  logic       div_in_range,
  output logic [2:0] mode,
  output logic       cfg_valid,
  output logic [1:0] clk_sel,
  output logic       fll_en,
  output logic       int_ref_en,
  output logic       ext_ref_en,
  output logic       dbg_clk_en,
  output logic       busy,
  output logic       clk_out
);
  localparam int NSRC = 3;
  localparam int AW   = NSRC * SYNC_STAGES;
  localparam logic [2:0] M_LOCK_INT = 3'd0, M_LOCK_EXT = 3'd1, M_BYP_INT = 3'd2,
                         M_BYP_LP   = 3'd3, M_BYP_EXT  = 3'd4;

  function automatic logic [1:0] src_of(input logic [2:0] m);
    case (m)
      M_LOCK_INT, M_LOCK_EXT: src_of = 2'd0;
      M_BYP_INT, M_BYP_LP:    src_of = 2'd1;
      default:                src_of = 2'd2;
    endcase
  endfunction

  function automatic logic [3:0] ens_of(input logic [2:0] m);
    case (m)
      M_LOCK_INT: ens_of = 4'b1101;
      M_LOCK_EXT: ens_of = 4'b1011;
      M_BYP_INT:  ens_of = 4'b1101;
      M_BYP_LP:   ens_of = 4'b0100;
      default:    ens_of = 4'b1011;
    endcase
  endfunction

  logic [2:0] mode_q, pend_q, req_mode;
  logic [1:0] sel_q;
  logic [3:0] ens_q;
  logic       busy_q, legal, keep_fll, switched;
  logic [NSRC-1:0] src_clk, gate, ack;
  logic [AW-1:0]   ack_pipe;

  assign keep_fll = dbg_active | ~low_pwr;

  always_comb begin
    legal    = 1'b0;
    req_mode = mode_q;
    if (src_sel == 2'b00) begin
      legal    = 1'b1;
      req_mode = ref_int ? M_LOCK_INT : M_LOCK_EXT;
    end else if (src_sel == 2'b01 && ref_int) begin
      legal    = 1'b1;
      req_mode = keep_fll ? M_BYP_INT : M_BYP_LP;
    end else if (src_sel == 2'b10 && !ref_int && keep_fll) begin
      legal    = 1'b1;
      req_mode = M_BYP_EXT;
    end
  end

  assign cfg_valid = legal & (ref_int | div_in_range);

  // Handshake back from the source domains.
  always_ff @(posedge ctl_clk or negedge rst_n)
    if (!rst_n) ack_pipe <= {SYNC_STAGES{3'b001}};
    else        ack_pipe <= {ack_pipe[AW-NSRC-1:0], gate};

  assign ack      = ack_pipe[AW-1 -: NSRC];
  assign switched = (ack == (3'b001 << sel_q));

  always_ff @(posedge ctl_clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_LOCK_INT;
      pend_q <= M_LOCK_INT;
      sel_q  <= 2'd0;
      ens_q  <= 4'b1101;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (cfg_valid && req_mode != mode_q) begin
        busy_q <= 1'b1;
        pend_q <= req_mode;
        sel_q  <= src_of(req_mode);
      end
    end else if (switched) begin
      busy_q <= 1'b0;
      mode_q <= pend_q;
      ens_q  <= ens_of(pend_q);
    end
  end

  assign src_clk = {ext_ref_clk, int_ref_clk, fll_clk};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic RST = (i == 0);
    logic want, g;
    logic [SYNC_STAGES-1:0] sh;
    assign want = (sel_q == 2'(i)) && ((gate & ~(3'b001 << i)) == 3'b000);
    always_ff @(posedge src_clk[i] or negedge rst_n)
      if (!rst_n) sh <= {SYNC_STAGES{RST}};
      else        sh <= {sh[SYNC_STAGES-2:0], want};
    always_ff @(negedge src_clk[i] or negedge rst_n)
      if (!rst_n) g <= RST;
      else        g <= sh[SYNC_STAGES-1];
    assign gate[i] = g;
  end

  assign clk_out = |(src_clk & gate);
  assign mode    = mode_q;
  assign clk_sel = sel_q;
  assign busy    = busy_q;
  assign {fll_en, int_ref_en, ext_ref_en, dbg_clk_en} = ens_q;

  AST_GATE_EXCLUSIVE: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    $onehot0(gate)); // R9
  AST_MODE_AT_COMMIT: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    !$stable(mode_q) |-> ($past(busy_q) && !busy_q)); // R8
  AST_SEL_HELD: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(sel_q)); // R8
  AST_NO_START_INVALID: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (!busy_q && !cfg_valid) |=> !busy_q); // R6
  AST_IDLE_ROUTED: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    !busy_q |-> (sel_q == src_of(mode_q))); // R7
  AST_LP_STOPS_FLL: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (!busy_q && mode_q == M_BYP_LP) |-> (!fll_en && !dbg_clk_en)); // R4
  AST_EXT_RANGE: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    ($rose(busy_q) && !$past(ref_int)) |-> $past(div_in_range)); // R5
endmodule

// File: tb/tb_clk_mode_ctrl.sv
`timescale 1ns/1ps
module tb_clk_mode_ctrl;
  logic ctl_clk = 0, fll_clk = 0, int_ref_clk = 0, ext_ref_clk = 0, rst_n = 0;
  logic [1:0] src_sel = 2'b00;
  logic ref_int = 1, low_pwr = 0, dbg_active = 0, div_in_range = 0;
  logic [2:0] mode;
  logic [1:0] clk_sel;
  logic cfg_valid, fll_en, int_ref_en, ext_ref_en, dbg_clk_en, busy, clk_out;

  int checks = 0, fails = 0, cur = 0;
  real last_edge = 0.0, w, min_hi = 1.0e9, min_lo = 1.0e9;
  int seen = 0;
  bit done = 0;

  always #2 ctl_clk = ~ctl_clk;
  always #3 fll_clk = ~fll_clk;
  always #7 int_ref_clk = ~int_ref_clk;
  always #5 ext_ref_clk = ~ext_ref_clk;

  clk_mode_ctrl dut (.*);

  always @(clk_out) if (rst_n) begin
    if (seen > 0) begin
      w = $realtime - last_edge;
      if (clk_out == 1'b0) begin if (w < min_hi) min_hi = w; end
      else begin if (w < min_lo) min_lo = w; end
    end
    last_edge = $realtime;
    seen++;
  end

  function automatic int exp_sel(input int m);
    return (m <= 1) ? 0 : (m <= 3) ? 1 : 2;
  endfunction
  function automatic int exp_en(input int m);
    case (m)
      0, 2: return 4'b1101;
      1, 4: return 4'b1011;
      default: return 4'b0100;
    endcase
  endfunction
  function automatic int per_ps(input int s);
    return (s == 0) ? 6000 : (s == 1) ? 14000 : 10000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ens();
    return {fll_en, int_ref_en, ext_ref_en, dbg_clk_en};
  endfunction

  task automatic measure(input int s, input string req);
    real t0;
    int p;
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); p = int'(($realtime - t0) * 1000.0);
    chk(p == per_ps(s), req, "clk_out period ps", p, per_ps(s));
  endtask

  task automatic t_reset;
    repeat (5) @(negedge ctl_clk);
    rst_n = 1;
    repeat (3) @(negedge ctl_clk);
    chk(mode == 0, "R1", "reset mode", mode, 0);
    chk(clk_sel == 0, "R1", "reset clk_sel", clk_sel, 0);
    chk(ens() == 4'b1101, "R1", "reset enables", ens(), 4'b1101);
    chk(!busy, "R1", "reset busy", busy, 0);
    measure(0, "R1");
  endtask

  task automatic go_mode(input logic [1:0] s, input logic r, input logic lp, input logic d,
                         input logic rg, input int em, input string tag);
    int n = 0;
    bit held = 1;
    @(negedge ctl_clk);
    src_sel = s; ref_int = r; low_pwr = lp; dbg_active = d; div_in_range = rg;
    #0.5;
    chk(cfg_valid == 1, "R5", "cfg_valid on legal setting", cfg_valid, 1);
    @(negedge ctl_clk);
    chk(busy == 1, "R8", "busy after request", busy, 1);
    chk(clk_sel == exp_sel(em), "R7", "clk_sel after accept", clk_sel, exp_sel(em));
    chk(mode == cur, "R8", "mode held at start", mode, cur);
    while (busy && n < 400) begin
      if (mode != cur || clk_sel != exp_sel(em)) held = 0;
      @(negedge ctl_clk);
      n++;
    end
    chk(held, "R8", "mode and clk_sel held while busy", held, 1);
    chk(!busy, "R8", "switch completed", busy, 0);
    chk(mode == em, tag, "committed mode", mode, em);
    chk(ens() == exp_en(em), "R4", "enables", ens(), exp_en(em));
    cur = em;
    measure(exp_sel(em), "R7");
  endtask

  task automatic try_invalid(input logic [1:0] s, input logic r, input logic lp, input logic d,
                             input logic rg, input string tag);
    bit quiet = 1;
    int e0 = ens();
    @(negedge ctl_clk);
    src_sel = s; ref_int = r; low_pwr = lp; dbg_active = d; div_in_range = rg;
    #0.5;
    chk(cfg_valid == 0, tag, "cfg_valid on illegal setting", cfg_valid, 0);
    repeat (6) begin
      @(negedge ctl_clk);
      if (busy || mode != cur || ens() != e0) quiet = 0;
    end
    chk(quiet, "R6", "illegal setting ignored", quiet, 1);
    chk(mode == cur, "R6", "mode held", mode, cur);
  endtask

  initial begin
    t_reset();
    go_mode(2'b00, 0, 0, 0, 1, 1, "R2");
    try_invalid(2'b00, 0, 0, 0, 0, "R5");
    go_mode(2'b10, 0, 0, 0, 1, 4, "R2");
    go_mode(2'b01, 1, 0, 0, 0, 2, "R2");
    go_mode(2'b01, 1, 1, 0, 0, 3, "R3");
    go_mode(2'b01, 1, 1, 1, 0, 2, "R3");
    go_mode(2'b01, 1, 1, 0, 0, 3, "R3");
    go_mode(2'b00, 1, 1, 0, 0, 0, "R2");
    go_mode(2'b01, 1, 0, 0, 0, 2, "R2");
    go_mode(2'b00, 0, 0, 0, 1, 1, "R2");
    go_mode(2'b10, 0, 1, 1, 1, 4, "R3");
    try_invalid(2'b10, 0, 1, 0, 1, "R3");
    try_invalid(2'b11, 1, 0, 0, 1, "R5");
    try_invalid(2'b01, 0, 0, 0, 1, "R5");
    try_invalid(2'b10, 1, 0, 0, 1, "R5");
    try_invalid(2'b10, 0, 0, 0, 0, "R5");
    go_mode(2'b01, 1, 1, 0, 0, 3, "R3");
    go_mode(2'b10, 0, 0, 0, 1, 4, "R2");
    go_mode(2'b00, 1, 0, 0, 0, 0, "R2");
    chk(int'(min_hi * 1000.0) >= 3000, "R9", "shortest high phase ps", int'(min_hi * 1000.0), 3000);
    chk(int'(min_lo * 1000.0) >= 3000, "R9", "shortest low phase ps", int'(min_lo * 1000.0), 3000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule